// File: doc/BRIEF.md
# Address Monitor Wake Trigger

This block is the hardware side of an arm-then-wait idle loop in a processor core. Software first arms the monitor with a physical address. The block aligns that address down to a monitored line and remembers it. The core then issues a wait request, which puts the block into a low-power waiting state. From then on the block watches a stream of store and snoop events. Each event carries an address and a memory-type tag.

A write-back store that lands in the armed line sets an event-pending flag. That flag ends the wait with a one-cycle wake pulse, and the pulse is tagged with a cause. A separate break input, such as an interrupt, also ends the wait, with a different cause. Software reads the cause to tell a real trigger from a spurious exit.

Power-management and fault events do not touch the pending flag. Waking clears both the armed state and the flag, so every new wait needs a fresh arm. A query port reports the smallest and the largest monitor line sizes, which are build-time powers of two. Comparisons use the largest size.

Top module: `mw_wake_top`

## Requirements
- R1: While armed, a store whose memory type is write-back (`2'b11`) and whose address falls in the armed line sets the pending flag. In the waiting state this raises `wake` in the cycle after the store is sampled, with `wake_cause` = `2'b01` (trigger).
- R2: Stores of any other memory type (`2'b00`, `2'b01`, `2'b10`) to the armed line never set the flag and never cause a wake.
- R3: An arm request whose memory type is not write-back leaves the monitor unarmed, so no later store can trigger.
- R4: Power-management (`pm_evt`) and fault (`fault_evt`) events leave the pending flag unchanged.
- R5: Entering the wait state does not re-arm the monitor. After a wake, a store to the old line does not wake a new wait until a new arm request arrives.
- R6: In the waiting state, `brk_evt` ends the wait with `wake_cause` = `2'b10` (break). If a trigger and a break occur in the same cycle, the trigger cause wins.
- R7: `min_line_sz` equals MIN_LINE_B and `max_line_sz` equals MAX_LINE_B at all times.
- R8: The armed address is aligned down to MAX_LINE_B bytes.
  - A store to the first or the last byte of that line hits.
  - A store one byte below the line misses, and so does a store one byte above it.
- R9: A wait request made while the pending flag is already set produces `wake` (cause trigger) in the next cycle, and `waiting` never rises.
- R10: An arm request clears any pending flag and latches the new line. A matching write-back store in the same cycle as the arm still sets the flag.
- R11: `wake` is high for exactly one cycle. With it, `waiting` falls and both the armed state and the pending flag are cleared.
- R12: After reset, `wake`, `wake_cause` and `waiting` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_req | input | 1 | Arm the monitor with `arm_addr` |
| arm_addr | input | ADDR_W | Physical address to monitor |
| arm_mtype | input | 2 | Memory type of the armed address (`2'b11` = write-back) |
| st_valid | input | 1 | Store/snoop event valid |
| st_addr | input | ADDR_W | Store/snoop address |
| st_mtype | input | 2 | Store memory type (`2'b11` = write-back) |
| wait_req | input | 1 | Enter the low-power wait |
| brk_evt | input | 1 | Break event (e.g. interrupt) that ends a wait |
| pm_evt | input | 1 | Power-management event; no effect on the flag |
| fault_evt | input | 1 | Fault event; no effect on the flag |
| wake | output | 1 | One-cycle wake pulse |
| wake_cause | output | 2 | `01` trigger, `10` break, `00` when no wake |
| waiting | output | 1 | Block is in the wait state |
| min_line_sz | output | SZ_W | Smallest monitor line size in bytes |
| max_line_sz | output | SZ_W | Largest monitor line size in bytes |

## Verification
The bench probes both edges of the aligned line and the bytes just outside it.
- A design that masked the wrong number of bits would either miss the last byte of the line or wake on the neighbouring line.

It also exercises the cases where the order of events matters.
- A store in the same cycle as an arm: a design that let the arm's clear win would lose that write and sleep forever.
- A wait issued with the flag already set: a design that always entered the wait would hang until a break.
- A trigger and a break in the same cycle: a design with the wrong priority would report a spurious exit for a real trigger.

Non-write-back stores and a non-write-back arm must leave the wait in place. Power and fault events must not drop a pending trigger. A second wait without a new arm must not be woken by a store, which exposes any design that re-arms on wait.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    MT_UC = 2'b00,
    MT_WC = 2'b01,
    MT_WT = 2'b10,
    MT_WB = 2'b11
  } mtype_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'b00,
    WK_TRIG = 2'b01,
    WK_BRK  = 2'b10
  } wcause_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } wstate_e;
endpackage

// File: rtl/mw_rst_sync.sv
module mw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mw_line_align.sv
module mw_line_align #(
  parameter int ADDR_W = 32,
  parameter int LINE_B = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] line
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE_B) - ADDR_W'(1);

  assign line = addr & ~LOW_MASK;
endmodule

// File: rtl/mw_flag_unit.sv
module mw_flag_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic [ADDR_W-1:0] arm_line,
  input  logic              arm_wb,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_line,
  input  logic              st_wb,
  input  logic              consume,
  output logic              pend_now,
  output logic              armed_q,
  output logic              pend_q
);
  logic [ADDR_W-1:0] line_q, line_d;
  logic              armed_d, pend_d, line_en;
  logic [ADDR_W-1:0] eff_line;
  logic              eff_armed, hit;

  always_comb begin
    eff_line  = arm_req ? arm_line : line_q;
    eff_armed = arm_req ? arm_wb   : armed_q;
    hit       = eff_armed & st_valid & st_wb & (st_line == eff_line);
    pend_now  = (arm_req ? 1'b0 : pend_q) | hit;
    line_en   = arm_req;
    line_d    = arm_line;
    if (consume) begin
      armed_d = 1'b0;
      pend_d  = 1'b0;
    end else begin
      armed_d = eff_armed;
      pend_d  = pend_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_d;
  end
endmodule

// File: rtl/mw_wait_fsm.sv
module mw_wait_fsm
  import mw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_req,
  input  logic      brk_evt,
  input  logic      pend_now,
  output logic      consume,
  output logic      wake_q,
  output wcause_e   cause_q,
  output logic      waiting
);
  wstate_e st_q, st_d;
  wcause_e cause_d;
  logic    fire_trig, fire_brk;

  always_comb begin
    fire_trig = pend_now & (((st_q == ST_IDLE) & wait_req) | (st_q == ST_WAIT));
    fire_brk  = ~fire_trig & (st_q == ST_WAIT) & brk_evt;
    consume   = fire_trig | fire_brk;
    if (consume)                          st_d = ST_IDLE;
    else if ((st_q == ST_IDLE) & wait_req) st_d = ST_WAIT;
    else                                  st_d = st_q;
    if (fire_trig)     cause_d = WK_TRIG;
    else if (fire_brk) cause_d = WK_BRK;
    else               cause_d = WK_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wake_q  <= 1'b0;
      cause_q <= WK_NONE;
    end else begin
      st_q    <= st_d;
      wake_q  <= consume;
      cause_q <= cause_d;
    end
  end

  assign waiting = (st_q == ST_WAIT);
endmodule

// File: rtl/mw_wake_top.sv
module mw_wake_top
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MIN_LINE_B = 32,
  parameter int MAX_LINE_B = 64,
  parameter int SZ_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_req,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic [1:0]        arm_mtype,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_mtype,
  input  logic              wait_req,
  input  logic              brk_evt,
  input  logic              pm_evt,
  input  logic              fault_evt,
  output logic              wake,
  output logic [1:0]        wake_cause,
  output logic              waiting,
  output logic [SZ_W-1:0]   min_line_sz,
  output logic [SZ_W-1:0]   max_line_sz
);
  localparam int NADDR = 2;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] raw_addr [NADDR];
  logic [ADDR_W-1:0] algn_addr [NADDR];
  logic              pend_now, consume, armed_q, pend_q;
  wcause_e           cause_q;

  mw_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign raw_addr[0] = arm_addr;
  assign raw_addr[1] = st_addr;

  for (genvar g = 0; g < NADDR; g++) begin : g_align
    mw_line_align #(.ADDR_W(ADDR_W), .LINE_B(MAX_LINE_B)) u_align (
      .addr(raw_addr[g]),
      .line(algn_addr[g])
    );
  end

  mw_flag_unit #(.ADDR_W(ADDR_W)) u_flag (
    .clk(clk), .rst_n(rst_sync_n),
    .arm_req(arm_req), .arm_line(algn_addr[0]), .arm_wb(arm_mtype == MT_WB),
    .st_valid(st_valid), .st_line(algn_addr[1]), .st_wb(st_mtype == MT_WB),
    .consume(consume), .pend_now(pend_now), .armed_q(armed_q), .pend_q(pend_q)
  );

  mw_wait_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .wait_req(wait_req), .brk_evt(brk_evt), .pend_now(pend_now),
    .consume(consume), .wake_q(wake), .cause_q(cause_q), .waiting(waiting)
  );

  assign wake_cause  = cause_q;
  assign min_line_sz = SZ_W'(MIN_LINE_B);
  assign max_line_sz = SZ_W'(MAX_LINE_B);
endmodule

// File: rtl/mw_wake_chk.sv
module mw_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       arm_req,
  input logic [1:0] arm_mtype,
  input logic       st_valid,
  input logic [1:0] st_mtype,
  input logic       wait_req,
  input logic       pm_evt,
  input logic       fault_evt,
  input logic       wake,
  input logic [1:0] wake_cause,
  input logic       waiting,
  input logic       armed_q,
  input logic       pend_q
);
  p_nonwb_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_req && arm_mtype != 2'b11) |=> !armed_q);

  p_nonwb_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !arm_req && st_valid && st_mtype != 2'b11) |=> !pend_q);

  p_pend_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (pm_evt || fault_evt) && !arm_req && !waiting && !wait_req) |=> pend_q);

  p_no_rearm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !armed_q && !arm_req) |=> !armed_q);

  p_early_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && wait_req && pend_q && !arm_req) |=> (wake && wake_cause == 2'b01 && !waiting));

  p_wake_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (!pend_q && !armed_q && !waiting));

  p_cause_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wake_cause == 2'b01 || wake_cause == 2'b10));

  p_cause_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wake |-> (wake_cause == 2'b00));
endmodule

bind mw_wake_top mw_wake_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .arm_req(arm_req), .arm_mtype(arm_mtype),
  .st_valid(st_valid), .st_mtype(st_mtype),
  .wait_req(wait_req), .pm_evt(pm_evt), .fault_evt(fault_evt),
  .wake(wake), .wake_cause(wake_cause), .waiting(waiting),
  .armed_q(armed_q), .pend_q(pend_q)
);

// File: tb/tb_mw_wake_top.sv
module tb_mw_wake_top;
  localparam int ADDR_W = 32;
  localparam int MINB   = 32;
  localparam int MAXB   = 64;
  localparam int SZ_W   = 16;
  localparam logic [ADDR_W-1:0] LA = 32'h0000_1040;
  localparam logic [ADDR_W-1:0] LB = 32'h0000_2080;

  logic clk, rst_n;
  logic arm_req, st_valid, wait_req, brk_evt, pm_evt, fault_evt;
  logic [ADDR_W-1:0] arm_addr, st_addr;
  logic [1:0] arm_mtype, st_mtype;
  logic wake, waiting;
  logic [1:0] wake_cause;
  logic [SZ_W-1:0] min_line_sz, max_line_sz;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  mw_wake_top #(.ADDR_W(ADDR_W), .MIN_LINE_B(MINB), .MAX_LINE_B(MAXB), .SZ_W(SZ_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .arm_req(arm_req), .arm_addr(arm_addr), .arm_mtype(arm_mtype),
    .st_valid(st_valid), .st_addr(st_addr), .st_mtype(st_mtype),
    .wait_req(wait_req), .brk_evt(brk_evt), .pm_evt(pm_evt), .fault_evt(fault_evt),
    .wake(wake), .wake_cause(wake_cause), .waiting(waiting),
    .min_line_sz(min_line_sz), .max_line_sz(max_line_sz)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every wake pulse is popped against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && wake === 1'b1) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected wake (R2/R3/R5) actual=cause %0d expected=no wake", wake_cause);
      end else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (wake_cause !== e) begin
          n_bad++;
          $display("FAIL %s wake cause actual=%0d expected=%0d", t, wake_cause, e);
        end
      end
    end
  end

  task automatic push_exp(input logic [1:0] c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic idle_in;
    arm_req = 0; st_valid = 0; wait_req = 0; brk_evt = 0; pm_evt = 0; fault_evt = 0;
  endtask

  task automatic step;
    @(negedge clk);
    idle_in();
  endtask

  task automatic do_arm(input logic [ADDR_W-1:0] a, input logic [1:0] mt);
    arm_req = 1; arm_addr = a; arm_mtype = mt;
    step();
  endtask

  task automatic do_store(input logic [ADDR_W-1:0] a, input logic [1:0] mt);
    st_valid = 1; st_addr = a; st_mtype = mt;
    step();
  endtask

  task automatic do_wait;
    wait_req = 1;
    step();
  endtask

  task automatic do_brk;
    brk_evt = 1;
    step();
  endtask

  task automatic drain(input string t);
    step();
    check({t, " queue drained"}, 32'(exp_q.size()), 0);
    check({t, " wake low after pulse (R11)"}, 32'(wake), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_in();
    arm_addr = '0; arm_mtype = 2'b00; st_addr = '0; st_mtype = 2'b00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R12 reset state, R7 query port
    check("R12 wake", 32'(wake), 0);
    check("R12 cause", 32'(wake_cause), 0);
    check("R12 waiting", 32'(waiting), 0);
    check("R7 min line", 32'(min_line_sz), MINB);
    check("R7 max line", 32'(max_line_sz), MAXB);

    // R1 basic trigger
    do_arm(LA, 2'b11);
    do_wait();
    check("R1 waiting after wait", 32'(waiting), 1);
    push_exp(2'b01, "R1");
    do_store(LA + 5, 2'b11);
    check("R11 waiting falls with wake", 32'(waiting), 0);
    drain("R1");

    // R2 non-WB stores ignored, then R6 break
    do_arm(LA, 2'b11);
    do_wait();
    do_store(LA, 2'b00);
    do_store(LA, 2'b01);
    do_store(LA, 2'b10);
    step();
    check("R2 still waiting after non-WB stores", 32'(waiting), 1);
    push_exp(2'b10, "R6 break");
    do_brk();
    drain("R6");

    // R3 non-WB arm
    do_arm(LA, 2'b00);
    do_wait();
    do_store(LA, 2'b11);
    step();
    check("R3 still waiting, no arm", 32'(waiting), 1);
    push_exp(2'b10, "R3 break exit");
    do_brk();
    drain("R3");

    // R8 line edges
    do_arm(LA + 32'h13, 2'b11);
    do_wait();
    do_store(LA - 1, 2'b11);
    do_store(LA + MAXB, 2'b11);
    step();
    check("R8 misses just outside line", 32'(waiting), 1);
    push_exp(2'b01, "R8 last byte");
    do_store(LA + MAXB - 1, 2'b11);
    drain("R8 last");
    do_arm(LA + MAXB - 1, 2'b11);
    do_wait();
    push_exp(2'b01, "R8 first byte");
    do_store(LA, 2'b11);
    drain("R8 first");

    // R4 pending survives pm/fault; R9 early wake
    do_arm(LA, 2'b11);
    do_store(LA, 2'b11);
    pm_evt = 1; step();
    fault_evt = 1; step();
    pm_evt = 1; fault_evt = 1; step();
    push_exp(2'b01, "R4/R9 early wake");
    wait_req = 1;
    @(negedge clk);
    check("R9 waiting never rises", 32'(waiting), 0);
    idle_in();
    drain("R9");

    // R5 no re-arm on wait
    do_wait();
    do_store(LA, 2'b11);
    step();
    check("R5 old line does not wake", 32'(waiting), 1);
    push_exp(2'b10, "R5 break exit");
    do_brk();
    drain("R5");

    // R10 arm clears pending
    do_arm(LA, 2'b11);
    do_store(LA, 2'b11);
    do_arm(LB, 2'b11);
    do_wait();
    check("R10 arm cleared pending", 32'(waiting), 1);
    push_exp(2'b01, "R10 new line");
    do_store(LB, 2'b11);
    drain("R10 a");

    // R10 same-cycle arm + store
    arm_req = 1; arm_addr = LB; arm_mtype = 2'b11;
    st_valid = 1; st_addr = LB + 8; st_mtype = 2'b11;
    step();
    push_exp(2'b01, "R10 same-cycle store");
    wait_req = 1;
    @(negedge clk);
    check("R10 immediate wake, no wait", 32'(waiting), 0);
    idle_in();
    drain("R10 b");

    // R6 priority: trigger beats break
    do_arm(LA, 2'b11);
    do_wait();
    push_exp(2'b01, "R6 trigger over break");
    st_valid = 1; st_addr = LA; st_mtype = 2'b11; brk_evt = 1;
    step();
    drain("R6 prio");

    check("R7 max line stable", 32'(max_line_sz), MAXB);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule